// File: doc/BRIEF.md
# Crank-Angle Triggered Pressure Sampler

This block sits between a quadrature shaft encoder, a slow analog-to-digital converter and a downstream consumer. It decodes the encoder in single-edge mode and keeps an angle index that spans one full engine cycle of two shaft revolutions. At 3600 counts per revolution the index runs over 7200 positions, each worth 0.1 degree, and wraps in both directions. Every change of the angle index starts exactly one conversion through a request/done handshake, so samples are tied to shaft position and not to a timer.

Nothing is sampled until the zero-reference input, which marks piston top position, has been seen once. From then on every finished conversion is written into a small first-word-fall-through queue as one word. The word holds the angle the conversion was started at, the sample, and a frame-start bit that marks angle zero, so the consumer can cut the stream into 7200-word frames. Two sticky flags report lost information: a count that arrived while the converter was still busy, and a word that found the queue full.

Top module: `crank_angle_sampler`

## Requirements
- R1: While `rst` is high on a rising clock edge, the angle, the queue and all flags are cleared. After reset `synced`, `missed_count`, `overflow`, `out_valid` and `adc_start` are all 0.
- R2: The encoder lines pass through a two-flop synchronizer. A rising edge of `enc_a` while `enc_b` is low adds one to the angle. A rising edge of `enc_a` while `enc_b` is high subtracts one. Any other edge does not count. A sampled cycle in which both `enc_a` and `enc_b` change is ignored.
- R3: The angle index stays within 0 to 7199. A forward count from 7199 gives 0, and a backward count from 0 gives 7199.
- R4: A rising edge on `enc_zero` loads the angle with 0 and sets `synced`. This takes priority over a count seen in the same cycle. While `synced` is low, no conversion is started.
- R5: Once synced, each change of the angle (a count or a zero load) raises `adc_start` for one cycle. The pulse comes on the third rising clock edge after the encoder input change is first sampled.
- R6: A cycle with `adc_done` high while a conversion is open writes one word into the queue. The word is `out_word[29:17]` = angle at the start, `[16:1]` = `adc_data` in that cycle, and `[0]` = frame-start bit. `adc_done` while no conversion is open writes nothing.
- R7: The frame-start bit `out_word[0]` is 1 exactly when the word's angle is 0.
- R8: A count that arrives while a conversion is open and `adc_done` is low starts nothing and sets `missed_count`, which stays set until reset. A count in the same cycle as `adc_done` closes the old conversion, starts a new one and leaves `missed_count` unchanged.
- R9: The queue holds 16 words and returns them in write order. `out_word` shows the oldest word whenever `out_valid` is high. `out_pop` with `out_valid` high removes that word.
- R10: A word written while the queue holds 16 words is dropped and sets `overflow`, which stays set until reset. The stored words are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| enc_zero | input | 1 | Zero-reference mark, asynchronous |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 16 | Conversion result |
| out_pop | input | 1 | Remove the oldest queued word |
| out_valid | output | 1 | Queue not empty |
| out_word | output | 30 | Oldest word: angle, sample, frame-start |
| synced | output | 1 | Zero reference has been seen |
| missed_count | output | 1 | Sticky: count lost while converting |
| overflow | output | 1 | Sticky: word lost on full queue |

## Verification
A new encoder count and the end of the open conversion can land in the same clock cycle. The bench provokes this by driving the `enc_a` rise so that its start cycle, known from the fixed latency of R5, matches the single cycle in which it drives `adc_done`. It then requires a fresh `adc_start`, a clear `missed_count` and two words with consecutive angles. The opposite case, a count arriving with `adc_done` low, has to set the flag and give only one word.

// File: rtl/angsamp_pkg.sv
package angsamp_pkg;
    localparam int ANGLE_W  = 13;
    localparam int SAMPLE_W = 16;

    typedef struct packed {
        logic [ANGLE_W-1:0]  angle;
        logic [SAMPLE_W-1:0] sample;
        logic                sof;
    } stream_word_t;

    localparam int WORD_W = $bits(stream_word_t);
endpackage

// File: rtl/enc_decoder.sv
module enc_decoder (
    input  logic clk,
    input  logic rst,
    input  logic enc_a,
    input  logic enc_b,
    input  logic enc_zero,
    output logic step_up,
    output logic step_dn,
    output logic zero_hit
);
    // bit0: first sync flop, bit1: second sync flop, bit2: previous value
    typedef struct packed {
        logic [2:0] a_sh;
        logic [2:0] b_sh;
        logic [2:0] z_sh;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic a_chg, b_chg, a_rise, clean;

    always_comb begin
        st_d      = st_q;
        st_d.a_sh = {st_q.a_sh[1:0], enc_a};
        st_d.b_sh = {st_q.b_sh[1:0], enc_b};
        st_d.z_sh = {st_q.z_sh[1:0], enc_zero};

        a_chg  = st_q.a_sh[1] ^ st_q.a_sh[2];
        b_chg  = st_q.b_sh[1] ^ st_q.b_sh[2];
        a_rise = st_q.a_sh[1] & ~st_q.a_sh[2];
        clean  = ~(a_chg & b_chg);

        step_up  = a_rise & clean & ~st_q.b_sh[1];
        step_dn  = a_rise & clean &  st_q.b_sh[1];
        zero_hit = st_q.z_sh[1] & ~st_q.z_sh[2];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2: a count is never both directions at once
    p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_dn}));

    // R2: a count needs A to have risen at the synchronizer output
    p_count_needs_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |=> $past(st_q.a_sh[1]) && !$past(st_q.a_sh[2]));
endmodule

// File: rtl/angle_track.sv
module angle_track #(
    parameter int COUNTS  = 7200,
    parameter int ANGLE_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_up,
    input  logic               step_dn,
    input  logic               zero_hit,
    output logic [ANGLE_W-1:0] angle,
    output logic               synced,
    output logic               trig
);
    localparam logic [ANGLE_W-1:0] LAST = ANGLE_W'(COUNTS - 1);

    typedef struct packed {
        logic [ANGLE_W-1:0] angle;
        logic               synced;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic moved;

    always_comb begin
        st_d  = st_q;
        moved = 1'b0;
        if (zero_hit) begin
            st_d.angle  = '0;
            st_d.synced = 1'b1;
            moved       = 1'b1;
        end else if (step_up) begin
            st_d.angle = (st_q.angle == LAST) ? '0 : st_q.angle + 1'b1;
            moved      = 1'b1;
        end else if (step_dn) begin
            st_d.angle = (st_q.angle == '0) ? LAST : st_q.angle - 1'b1;
            moved      = 1'b1;
        end
        trig = moved & st_d.synced;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign angle  = st_d.angle;
    assign synced = st_q.synced;

    // R3: the index never leaves its range
    p_angle_range_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.angle <= LAST);

    // R3: forward from the last position lands on zero
    p_fwd_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step_up && !zero_hit && st_q.angle == LAST) |=> st_q.angle == '0);

    // R4: nothing is triggered before the zero reference
    p_no_trig_unsynced_r4: assert property (@(posedge clk) disable iff (rst)
        (!st_q.synced && !zero_hit) |-> !trig);

    // R4: synced is sticky
    p_synced_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.synced |=> st_q.synced);
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import angsamp_pkg::*;
#(
    parameter int A_W = ANGLE_W,
    parameter int S_W = SAMPLE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trig,
    input  logic [A_W-1:0] angle,
    input  logic           adc_done,
    input  logic [S_W-1:0] adc_data,
    output logic           adc_start,
    output logic           push,
    output stream_word_t   push_word,
    output logic           missed
);
    typedef struct packed {
        logic           busy;
        logic           start;
        logic           missed;
        logic [A_W-1:0] tag;
    } cc_state_t;

    cc_state_t st_d, st_q;
    logic finishing;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        finishing  = st_q.busy & adc_done;

        push             = finishing;
        push_word.angle  = st_q.tag;
        push_word.sample = adc_data;
        push_word.sof    = (st_q.tag == '0);

        if (finishing) st_d.busy = 1'b0;

        if (trig) begin
            if (!st_q.busy || finishing) begin
                st_d.busy  = 1'b1;
                st_d.start = 1'b1;
                st_d.tag   = angle;
            end else begin
                st_d.missed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign adc_start = st_q.start;
    assign missed    = st_q.missed;

    // R5: a request only follows a free converter
    p_start_when_free_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.start |-> (!$past(st_q.busy) || $past(adc_done)));

    // R5: a request leaves the converter marked busy
    p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.start |-> st_q.busy);

    // R8: lost-count flag is sticky
    p_missed_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.missed |=> st_q.missed);

    // R7: frame-start bit marks angle zero only
    p_sof_zero_r7: assert property (@(posedge clk) disable iff (rst)
        push |-> (push_word.sof == (push_word.angle == '0)));
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
    import angsamp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  stream_word_t push_word,
    input  logic         pop,
    output logic         valid,
    output stream_word_t head,
    output logic         overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != FULL);

        if (push && !do_push) st_d.ovf = 1'b1;

        if (do_push) begin
            st_d.mem[st_q.wr] = push_word;
            st_d.wr           = st_q.wr + 1'b1;
        end
        if (do_pop) st_d.rd = st_q.rd + 1'b1;

        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid    = (st_q.cnt != '0);
    assign head     = stream_word_t'(st_q.mem[st_q.rd]);
    assign overflow = st_q.ovf;

    // R9: occupancy never exceeds the depth
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL);

    // R10: overflow flag is sticky
    p_no_overflow_clear_r10: assert property (@(posedge clk) disable iff (rst)
        st_q.ovf |=> st_q.ovf);

    // R10: a write on a full queue leaves the occupancy unchanged without a pop
    p_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == FULL && push && !pop) |=> st_q.cnt == FULL);
endmodule

// File: rtl/crank_angle_sampler.sv
module crank_angle_sampler
    import angsamp_pkg::*;
#(
    parameter int COUNTS_PER_CYCLE = 7200,
    parameter int FIFO_DEPTH       = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enc_a,
    input  logic                enc_b,
    input  logic                enc_zero,
    output logic                adc_start,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                out_pop,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word,
    output logic                synced,
    output logic                missed_count,
    output logic                overflow
);
    logic               step_up, step_dn, zero_hit, trig, push;
    logic [ANGLE_W-1:0] angle;
    stream_word_t       push_word, head;

    enc_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .enc_zero (enc_zero),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .zero_hit (zero_hit)
    );

    angle_track #(
        .COUNTS  (COUNTS_PER_CYCLE),
        .ANGLE_W (ANGLE_W)
    ) u_trk (
        .clk      (clk),
        .rst      (rst),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .zero_hit (zero_hit),
        .angle    (angle),
        .synced   (synced),
        .trig     (trig)
    );

    conv_ctrl u_cc (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .angle     (angle),
        .adc_done  (adc_done),
        .adc_data  (adc_data),
        .adc_start (adc_start),
        .push      (push),
        .push_word (push_word),
        .missed    (missed_count)
    );

    sample_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (push_word),
        .pop       (out_pop),
        .valid     (out_valid),
        .head      (head),
        .overflow  (overflow)
    );

    assign out_word = head;

    // R5: the request is a single-cycle pulse unless a conversion ended at once
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> (!adc_start || $past(adc_done)));
endmodule

// File: tb/sim_crank_angle_sampler.sv
module sim_crank_angle_sampler;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_zero = 1'b0;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = '0;
    logic        out_pop = 1'b0;
    logic        adc_start, out_valid, synced, missed_count, overflow;
    logic [29:0] out_word;

    int checks = 0;
    int errors = 0;
    int n_starts = 0;
    bit auto_en = 1'b1;
    bit finished = 1'b0;
    logic [15:0] next_val = 16'hA000;
    logic [15:0] given[$];

    always #5 clk = ~clk;

    crank_angle_sampler u0 (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_zero(enc_zero),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
        .out_pop(out_pop), .out_valid(out_valid), .out_word(out_word),
        .synced(synced), .missed_count(missed_count), .overflow(overflow)
    );

    always @(negedge clk) if (adc_start) n_starts++;

    // converter model: answers each request after three cycles
    initial begin
        forever begin
            @(negedge clk);
            if (auto_en && adc_start) begin
                repeat (3) @(negedge clk);
                adc_done = 1'b1;
                adc_data = next_val;
                given.push_back(next_val);
                next_val = next_val + 16'd1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        given.delete();
    endtask

    task automatic step_fwd();
        enc_a = 1'b1; wait_n(8);
        enc_a = 1'b0; wait_n(4);
    endtask

    task automatic step_bwd();
        enc_b = 1'b1; wait_n(4);
        enc_a = 1'b1; wait_n(8);
        enc_a = 1'b0; wait_n(4);
        enc_b = 1'b0; wait_n(4);
    endtask

    task automatic zero_mark();
        enc_zero = 1'b1; wait_n(4);
        enc_zero = 1'b0; wait_n(8);
    endtask

    task automatic give_done(input logic [15:0] v);
        adc_done = 1'b1;
        adc_data = v;
        given.push_back(v);
        wait_n(1);
        adc_done = 1'b0;
    endtask

    task automatic pop_check(input int exp_angle, input string req);
        logic [15:0] exp_s;
        wait_n(6);
        check(out_valid == 1'b1, req, "word present", int'(out_valid), 1);
        if (out_valid) begin
            exp_s = (given.size() > 0) ? given.pop_front() : 16'h0;
            check(int'(out_word[29:17]) == exp_angle, req, "angle",
                  int'(out_word[29:17]), exp_angle);
            check(out_word[16:1] == exp_s, req, "sample",
                  int'(out_word[16:1]), int'(exp_s));
            check(out_word[0] == (exp_angle == 0), "R7", "frame-start bit",
                  int'(out_word[0]), int'(exp_angle == 0));
            out_pop = 1'b1;
            wait_n(1);
            out_pop = 1'b0;
        end
    endtask

    task automatic t_reset_state();   // R1
        check(synced == 0 && missed_count == 0 && overflow == 0, "R1", "flags",
              int'({synced, missed_count, overflow}), 0);
        check(out_valid == 0 && adc_start == 0, "R1", "valid/start",
              int'({out_valid, adc_start}), 0);
    endtask

    task automatic t_unsynced();   // R4
        int s0 = n_starts;
        step_fwd(); step_fwd(); step_fwd();
        check(n_starts == s0, "R4", "starts before zero", n_starts - s0, 0);
        check(out_valid == 0 && synced == 0, "R4", "no output before zero",
              int'({out_valid, synced}), 0);
    endtask

    task automatic t_zero();   // R4 R6 R7
        zero_mark();
        check(synced == 1, "R4", "synced after zero", int'(synced), 1);
        pop_check(0, "R4");
    endtask

    task automatic t_forward();   // R2 R5
        for (int i = 1; i <= 3; i++) begin
            int s0 = n_starts;
            step_fwd();
            check(n_starts == s0 + 1, "R5", "one start per count", n_starts - s0, 1);
            pop_check(i, "R2");
        end
    endtask

    task automatic t_backward();   // R2
        step_bwd();
        pop_check(2, "R2");
    endtask

    task automatic t_invalid();   // R2
        int s0 = n_starts;
        enc_a = 1'b1; enc_b = 1'b1; wait_n(8);
        enc_a = 1'b0; enc_b = 1'b0; wait_n(8);
        check(n_starts == s0, "R2", "simultaneous change ignored", n_starts - s0, 0);
        check(out_valid == 0, "R2", "no word on invalid change", int'(out_valid), 0);
        step_fwd();
        pop_check(3, "R2");
    endtask

    task automatic t_wrap();   // R3 R7
        step_bwd(); pop_check(2, "R3");
        step_bwd(); pop_check(1, "R3");
        step_bwd(); pop_check(0, "R3");
        step_bwd(); pop_check(7199, "R3");
        step_fwd(); pop_check(0, "R3");
    endtask

    task automatic t_done_idle();   // R6
        auto_en = 1'b0;
        adc_done = 1'b1; adc_data = 16'h1234; wait_n(1);
        adc_done = 1'b0; wait_n(6);
        check(out_valid == 0, "R6", "done while idle writes nothing", int'(out_valid), 0);
        auto_en = 1'b1;
    endtask

    task automatic t_missed();   // R8
        int s0;
        auto_en = 1'b0;
        s0 = n_starts;
        step_fwd();
        check(missed_count == 0, "R8", "no miss yet", int'(missed_count), 0);
        step_fwd();
        check(n_starts == s0 + 1, "R8", "no second start while busy", n_starts - s0, 1);
        check(missed_count == 1, "R8", "miss flagged", int'(missed_count), 1);
        give_done(16'h5A5A);
        pop_check(1, "R8");
        check(out_valid == 0, "R8", "only one word", int'(out_valid), 0);
        auto_en = 1'b1;
        step_fwd();
        pop_check(3, "R8");
        check(missed_count == 1, "R8", "miss sticky", int'(missed_count), 1);
    endtask

    task automatic t_same_cycle();   // R8 R5
        do_reset();
        t_reset_state();
        zero_mark();
        pop_check(0, "R1");
        auto_en = 1'b0;
        step_fwd();                      // angle 1 open, not answered
        enc_a = 1'b1;  wait_n(1);        // first sampled at next edge
        wait_n(1);
        adc_done = 1'b1; adc_data = 16'h7711; given.push_back(16'h7711);
        wait_n(1);                       // start on third edge
        adc_done = 1'b0;
        check(adc_start == 1, "R5", "start on third edge with done", int'(adc_start), 1);
        check(missed_count == 0, "R8", "no miss when done coincides", int'(missed_count), 0);
        wait_n(4);
        enc_a = 1'b0;
        pop_check(1, "R8");
        give_done(16'h7722);
        pop_check(2, "R8");
        wait_n(4);
        auto_en = 1'b1;
    endtask

    task automatic t_overflow();   // R9 R10
        for (int i = 0; i < 16; i++) step_fwd();
        wait_n(8);
        check(overflow == 0, "R10", "no overflow at 16 words", int'(overflow), 0);
        step_fwd();
        wait_n(8);
        check(overflow == 1, "R10", "overflow on 17th word", int'(overflow), 1);
        for (int i = 0; i < 16; i++) pop_check(3 + i, "R9");
        given.delete();
        wait_n(2);
        check(out_valid == 0, "R10", "17th word dropped", int'(out_valid), 0);
        check(overflow == 1, "R10", "overflow sticky", int'(overflow), 1);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        t_reset_state();
        t_unsynced();
        t_zero();
        t_forward();
        t_backward();
        t_invalid();
        t_wrap();
        t_done_idle();
        t_missed();
        t_same_cycle();
        t_overflow();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule